// File: doc/BRIEF.md
# Register Access Lock Controller

This block sits between a simple register bus and the small register space of a sensor device. It decides whether each read or write is allowed. It models a set of volatile data registers and one sticky lock-request bit, and it talks to the non-volatile store through a sampled lock input and a commit pulse.

After every power-on reset, all access is refused. Access opens only when a secret 30-bit key is written to the key address before a tick-counted window expires. A permanent lock bit can also be committed to non-volatile storage. That bit is read once after the next power-on. While it is set, no key can reopen access.

Every access gets a registered response one cycle after its strobe, carried on `ack` and `err`. While access is closed, read data is forced to zero.

Top module: `reg_access_gate`

## Requirements
- R1: After `por_n` is released, access is closed. Any read, and any write other than the correct key to the key address, returns `ack`=1 with `err`=1 and `rdata`=0 in the cycle after the strobe.
- R2: A write to `KEY_ADDR` (default 0x24) with `wdata[29:0]` equal to `ACCESS_KEY` opens access when three conditions hold: the window is open, the permanent lock is clear, and at least one clock has passed since reset. That write is answered `ack`=1, `err`=0. Every later access to a mapped address succeeds.
- R3: Each cycle with `tick`=1 advances a window counter, which saturates at `WIN_TICKS` (default 8). Once `WIN_TICKS` ticks have been counted with access still closed, the correct key is refused with `err`=1 until the next power-on.
- R4: A wrong key value, or the right value at another address, returns `err`=1. It leaves access closed and does not shorten the window, so the correct key still opens access after `WIN_TICKS`-1 ticks.
- R5: Asserting `por_n` low always closes access again, and clears the data registers and the lock-request bit.
- R6: `nv_lock_in` is sampled once, on the first clock after reset. If it is 1, the correct key is refused for that whole power-on. Changes to `nv_lock_in` after that first clock have no effect.
- R7: While access is open, a write to `LOCK_ADDR` (default 0x20) with bit 0 set does two things. It raises `nv_lock_wr` for one cycle, aligned with `ack`, and it sets the lock-request bit, which reads back at bit 0 of `LOCK_ADDR`. Writing 0 never clears that bit, and access stays open for the rest of the power-on.
- R8: While access is open, data registers at addresses 0 to `NREG`-1 accept writes and return their value in `rdata` one cycle after a read. Reads of `KEY_ADDR` return 0 without error. Any other address returns `err`=1, and so does any cycle with both strobes high.
- R9: Writes made while access is closed do not change any data register, so the register still reads its previous value once access opens.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, asynchronous, active low |
| tick | input | 1 | Timebase pulse for the unlock window |
| nv_lock_in | input | 1 | Stored permanent lock bit from non-volatile memory |
| addr | input | AW | Register address |
| wdata | input | DW | Write data |
| wr_en | input | 1 | Write strobe, one cycle per access |
| rd_en | input | 1 | Read strobe, one cycle per access |
| rdata | output | DW | Read data, valid with `ack` |
| ack | output | 1 | Response valid, one cycle after a strobe |
| err | output | 1 | Access refused or unmapped, valid with `ack` |
| nv_lock_wr | output | 1 | One-cycle request to commit the permanent lock bit |

## Verification
Every response (`ack`, `err`, `rdata`, `nv_lock_wr`) is registered at the clock edge that sees the strobe. The bench therefore drives a strobe on a falling edge, holds it through one rising edge, and samples the outputs on the next falling edge. A change in access state from a key write takes effect at that same edge, so the very next access already sees the new state. Ticks are counted at the edge where they are high. The bench pulses exactly `WIN_TICKS`-1 or `WIN_TICKS` ticks before the key write, to land on each side of the window limit.

// File: rtl/reg_access_gate.sv
module reg_access_gate #(
  parameter int AW = 8,
  parameter int DW = 32,
  parameter int NREG = 16,
  parameter int WIN_TICKS = 8,
  parameter int KEY_W = 30,
  parameter logic [KEY_W-1:0] ACCESS_KEY = 30'h1A2B3C4D,
  parameter logic [AW-1:0] KEY_ADDR = 8'h24,
  parameter logic [AW-1:0] LOCK_ADDR = 8'h20
) (
  input  logic          clk,
  input  logic          por_n,
  input  logic          tick,
  input  logic          nv_lock_in,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  input  logic          wr_en,
  input  logic          rd_en,
  output logic [DW-1:0] rdata,
  output logic          ack,
  output logic          err,
  output logic          nv_lock_wr
);
  localparam int CW = $clog2(WIN_TICKS + 1);
  localparam int IW = $clog2(NREG);

  logic          open_q, perm_q, smp_q, req_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] regs_q [NREG];

  wire expired  = (cnt_q == CW'(WIN_TICKS));
  wire any_acc  = wr_en | rd_en;
  wire clash    = wr_en & rd_en;
  wire hit_key  = (addr == KEY_ADDR);
  wire hit_lock = (addr == LOCK_ADDR);
  wire hit_data = (addr < AW'(NREG));
  wire key_ok   = wr_en & ~rd_en & hit_key & (wdata[KEY_W-1:0] == ACCESS_KEY)
                  & ~expired & ~perm_q & smp_q;
  wire good     = ~clash & (key_ok | (open_q & (hit_key | hit_lock | hit_data)));
  wire open_wr  = good & wr_en & open_q;
  wire open_rd  = good & rd_en & open_q;
  wire [IW-1:0] idx = addr[IW-1:0];

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      open_q     <= 1'b0;
      perm_q     <= 1'b1;
      smp_q      <= 1'b0;
      req_q      <= 1'b0;
      cnt_q      <= '0;
      ack        <= 1'b0;
      err        <= 1'b0;
      rdata      <= '0;
      nv_lock_wr <= 1'b0;
    end else begin
      ack        <= any_acc;
      err        <= any_acc & ~good;
      nv_lock_wr <= 1'b0;
      rdata      <= '0;
      if (!smp_q) begin
        smp_q  <= 1'b1;
        perm_q <= nv_lock_in;
      end
      if (tick && !expired) cnt_q <= cnt_q + 1'b1;
      if (key_ok) open_q <= 1'b1;
      if (open_wr && hit_lock && wdata[0]) begin
        req_q      <= 1'b1;
        nv_lock_wr <= 1'b1;
      end
      if (open_rd) begin
        if (hit_lock)      rdata <= DW'(req_q);
        else if (hit_data) rdata <= regs_q[idx];
      end
    end
  end

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      for (int i = 0; i < NREG; i++) regs_q[i] <= '0;
    end else if (open_wr && hit_data) begin
      regs_q[idx] <= wdata;
    end
  end

  p_locked_read_refused_r1: assert property (@(posedge clk) disable iff (!por_n)
    (!open_q && rd_en) |=> (ack && err && rdata == '0));
  p_open_sticky_r2: assert property (@(posedge clk) disable iff (!por_n)
    open_q |=> open_q);
  p_window_saturates_r3: assert property (@(posedge clk) disable iff (!por_n)
    expired |=> expired);
  p_no_late_unlock_r3: assert property (@(posedge clk) disable iff (!por_n)
    (expired && !open_q) |=> !open_q);
  p_perm_blocks_r6: assert property (@(posedge clk) disable iff (!por_n)
    (smp_q && perm_q) |-> !open_q);
  p_commit_with_ack_r7: assert property (@(posedge clk) disable iff (!por_n)
    nv_lock_wr |-> (ack && !err));
  p_req_sticky_r7: assert property (@(posedge clk) disable iff (!por_n)
    req_q |=> req_q);
  p_zero_when_locked_r9: assert property (@(posedge clk) disable iff (!por_n)
    !open_q |=> rdata == '0);
endmodule

// File: tb/reg_access_gate_tb.sv
module reg_access_gate_tb_top;
  localparam int NREG = 16;
  localparam int WIN = 8;
  localparam logic [29:0] KEY = 30'h1A2B3C4D;
  localparam logic [7:0] KADDR = 8'h24;
  localparam logic [7:0] LADDR = 8'h20;

  logic clk = 0, por_n = 0, tick = 0, nv_lock_in = 0;
  logic [7:0] addr = 0;
  logic [31:0] wdata = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic ack, err, nv_lock_wr;

  int total = 0, bad = 0, cycles = 0;
  bit done = 0;
  logic [31:0] shadow [NREG];
  bit r_ack, r_err, r_pw;
  logic [31:0] r_data;

  always #10 clk = ~clk;

  reg_access_gate dut_i (
    .clk(clk), .por_n(por_n), .tick(tick), .nv_lock_in(nv_lock_in),
    .addr(addr), .wdata(wdata), .wr_en(wr_en), .rd_en(rd_en),
    .rdata(rdata), .ack(ack), .err(err), .nv_lock_wr(nv_lock_wr));

  task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic access(input bit w, input logic [7:0] a, input logic [31:0] d);
    @(negedge clk);
    wr_en = w; rd_en = !w; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 0; rd_en = 0;
    r_ack = ack; r_err = err; r_data = rdata; r_pw = nv_lock_wr;
  endtask

  task automatic expect_resp(input string tag, input bit e_err, input logic [31:0] e_data);
    check(r_ack == 1'b1, tag, 32'(r_ack), 32'd1);
    check(r_err == e_err, tag, 32'(r_err), 32'(e_err));
    check(r_data == e_data, tag, r_data, e_data);
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1;
      @(negedge clk); tick = 0;
    end
  endtask

  task automatic power_cycle(input bit nv);
    @(negedge clk); por_n = 0; nv_lock_in = nv;
    for (int i = 0; i < NREG; i++) shadow[i] = '0;
    repeat (2) @(negedge clk);
    por_n = 1;
    @(negedge clk);
  endtask

  function automatic bit exp_err_of(input logic [7:0] a);
    return !(a < NREG || a == KADDR || a == LADDR);
  endfunction

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000 && !done) begin
      done = 1;
      bad++; total++;
      $display("FAIL watchdog act=%0d exp=%0d", cycles, 100000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd7);
    power_cycle(0);
    check(ack == 0 && err == 0 && rdata == 0 && nv_lock_wr == 0, "R1 reset state",
          {ack, err, nv_lock_wr, 29'(rdata)}, 32'd0);

    access(0, 8'h03, 0);             expect_resp("R1 locked read", 1, 0);
    access(1, 8'h03, 32'hDEADBEEF);  expect_resp("R9 locked write refused", 1, 0);
    access(1, KADDR, {2'b00, KEY ^ 30'h1});   expect_resp("R4 wrong key", 1, 0);
    access(1, 8'h25, {2'b00, KEY});  expect_resp("R4 key at wrong address", 1, 0);
    access(0, 8'h03, 0);             expect_resp("R4 still closed", 1, 0);
    ticks(WIN - 1);
    access(1, KADDR, {2'b00, KEY});  expect_resp("R2 R4 key inside window", 0, 0);
    access(0, 8'h03, 0);             expect_resp("R9 locked write had no effect", 0, 0);
    access(0, KADDR, 0);             expect_resp("R8 key register reads zero", 0, 0);
    ticks(3);
    access(0, 8'h05, 0);             expect_resp("R3 open survives window end", 0, 0);

    for (int n = 0; n < 300; n++) begin
      logic [7:0] a;
      logic [31:0] d;
      bit w;
      logic [31:0] e;
      int k;
      k = $urandom_range(0, 9);
      a = (k < 6) ? 8'($urandom_range(0, NREG - 1)) :
          (k == 6) ? KADDR : (k == 7) ? LADDR : 8'($urandom_range(NREG, 255));
      if (a == LADDR) w = 0; else w = $urandom_range(0, 1) == 1;
      d = $urandom;
      access(w, a, d);
      e = 0;
      if (!w && a < NREG) e = shadow[a[3:0]];
      if (w && a < NREG) shadow[a[3:0]] = d;
      expect_resp("R8 random access", exp_err_of(a), e);
    end

    @(negedge clk); wr_en = 1; rd_en = 1; addr = 8'h01;
    @(negedge clk); wr_en = 0; rd_en = 0;
    check(ack && err, "R8 both strobes", 32'(err), 32'd1);

    power_cycle(0);
    access(0, 8'h01, 0);             expect_resp("R5 power cycle relocks", 1, 0);
    ticks(WIN);
    access(1, KADDR, {2'b00, KEY});  expect_resp("R3 key after window", 1, 0);
    access(0, 8'h01, 0);             expect_resp("R3 still closed", 1, 0);

    power_cycle(0);
    nv_lock_in = 1;
    access(1, KADDR, {2'b00, KEY});  expect_resp("R6 late nv change ignored", 0, 0);
    access(0, 8'h01, 0);             expect_resp("R5 data cleared by power cycle", 0, 0);
    access(1, LADDR, 0);             expect_resp("R7 write zero", 0, 0);
    check(r_pw == 0, "R7 no commit for zero", 32'(r_pw), 0);
    access(0, LADDR, 0);             expect_resp("R7 lock bit clear", 0, 0);
    access(1, LADDR, 1);             expect_resp("R7 set lock", 0, 0);
    check(r_pw == 1, "R7 commit pulse", 32'(r_pw), 1);
    @(negedge clk);
    check(nv_lock_wr == 0, "R7 pulse one cycle", 32'(nv_lock_wr), 0);
    access(1, LADDR, 0);             expect_resp("R7 clear attempt", 0, 0);
    access(0, LADDR, 0);             expect_resp("R7 lock bit sticky", 0, 1);
    access(1, 8'h02, 32'h5A5A5A5A);  expect_resp("R7 session still open", 0, 0);
    access(0, 8'h02, 0);             expect_resp("R7 session read", 0, 32'h5A5A5A5A);

    power_cycle(1);
    access(1, KADDR, {2'b00, KEY});  expect_resp("R6 permanent lock refuses key", 1, 0);
    access(0, LADDR, 0);             expect_resp("R6 lock register refused", 1, 0);
    access(0, 8'h02, 0);             expect_resp("R6 data refused", 1, 0);

    done = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule